// File: doc/BRIEF.md
# Prefixed Bit Test / Clear / Set Unit

This unit executes the second byte of a two-byte prefixed instruction on an 8-bit accumulator-style processor. After the prefix has been fetched, the core presents the following byte on `opcode_i` with a one-cycle `start_i` strobe. The unit splits the byte into three fields:

- an operation class,
- a bit index,
- an operand selector.

It reads the operand from an eight-entry register view, in which one selector value stands for the memory byte addressed by the HL pair. It then tests, clears or sets the indexed bit, writes the result back where the operand came from, and reports updated flags. It signals completion with `done_o`.

Register operands finish in the cycle after the start. A memory operand costs one read cycle on a port with one cycle of read latency. For clear and set, one write cycle follows the read, and `done_o` comes only after the write. Shift and rotate bytes (class 0) are not executed: they raise `err_o` together with `done_o` and touch nothing.

Top module: `bitop_unit`

## Requirements
- R1: The byte is split into class = bits [7:6], bit index = bits [5:3] and selector = bits [2:0]. Selector codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at HL, 7=A. Register accesses use the selector as `rf_rsel_o` and as `rf_wsel_o`.
- R2: Class 1 (test) sets Z to 1 when the indexed bit of the operand is 0, and to 0 when that bit is 1.
- R3: A test pulses `flag_we_o` once, with N=0, H=1 and C equal to `flags_i` C. It writes nothing back to a register or to memory. The flag layout is Z=bit 3, N=bit 2, H=bit 1, C=bit 0.
- R4: Class 2 (clear) writes the operand back, to the same selector, with the indexed bit forced to 0. All other bits keep their value.
- R5: Class 3 (set) writes the operand back, to the same selector, with the indexed bit forced to 1.
- R6: Clear and set never pulse `flag_we_o`, and `flags_o` equals `flags_i` while either runs.
- R7: Selector 6 issues one memory read at the HL value captured at start. Read data is taken one cycle later. Clear and set then issue one write of the modified byte to the same address, and `done_o` follows in the next cycle.
- R8: The latency from start to `done_o` is 1 cycle for register operands and for class 0, 2 cycles for a memory test, and 3 cycles for a memory clear or set. `done_o` lasts exactly one cycle, and a `start_i` that arrives while an operation runs is ignored.
- R9: Class 0 raises `err_o` together with `done_o`. It causes no register write, no memory read or write, and no flag write.
- R10: While reset is asserted, `done_o`, `err_o`, `rf_we_o`, `mem_re_o`, `mem_we_o` and `flag_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| opcode_i | input | 8 | Second instruction byte |
| hl_i | input | ADDR_W | Current HL pair, captured at start |
| rf_rsel_o | output | 3 | Register read selector |
| rf_rdata_i | input | 8 | Register read data, combinational |
| rf_we_o | output | 1 | Register write enable |
| rf_wsel_o | output | 3 | Register write selector |
| rf_wdata_o | output | 8 | Register write data |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| flags_o | output | 4 | Flags after the operation |
| flag_we_o | output | 1 | Flag write enable |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Unsupported class, valid with done_o |

## Verification
The main function is driven with operand patterns chosen so that each result tells a fault apart. Single set bits and single cleared bits are placed at the indexed position, which separates a correct bit index from a neighbouring one. Operands whose indexed bit already holds the target value expose an inverted or toggling mask. A varying incoming carry shows whether the test passes C through or forces it.

Every class is run against both register and memory selectors, including H and L. This separates write-back to the right selector from write-back to the HL target, and shows whether the memory path holds the address captured at start. Class 0 with the memory selector confirms that no read is issued, and a second start during a memory read-modify-write confirms that a start arriving while busy is dropped.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned FLG_W  = 4;

  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

  localparam int unsigned FLG_Z = 3;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_H = 1;
  localparam int unsigned FLG_C = 0;

  typedef enum logic [1:0] {
    CLS_ROT  = 2'd0,
    CLS_TEST = 2'd1,
    CLS_CLR  = 2'd2,
    CLS_SET  = 2'd3
  } op_cls_e;

  typedef struct packed {
    op_cls_e          cls;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
  } op_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_MRD,
    ST_MOP,
    ST_FIN
  } state_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [DATA_W-1:0] opcode_i,
  output op_dec_t           dec_o,
  output logic              is_mem_o,
  output logic              is_wr_o,
  output logic              is_bad_o
);
  assign dec_o    = op_dec_t'(opcode_i);
  assign is_mem_o = (dec_o.sel == SEL_MEM);
  assign is_wr_o  = (dec_o.cls == CLS_CLR) || (dec_o.cls == CLS_SET);
  assign is_bad_o = (dec_o.cls == CLS_ROT);
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
(
  input  op_cls_e           cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLG_W-1:0]  flags_o
);
  logic [DATA_W-1:0] mask;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = (idx_i == IDX_W'(b));
  end

  always_comb begin
    unique case (cls_i)
      CLS_CLR: result_o = opnd_i & ~mask;
      CLS_SET: result_o = opnd_i | mask;
      default: result_o = opnd_i;
    endcase
  end

  always_comb begin
    flags_o = flags_i;
    if (cls_i == CLS_TEST) begin
      flags_o[FLG_Z] = ~|(opnd_i & mask);
      flags_o[FLG_N] = 1'b0;
      flags_o[FLG_H] = 1'b1;
    end
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_mem_i,
  input  logic is_bad_i,
  input  logic is_wr_i,
  output logic idle_o,
  output logic ld_o,
  output logic exec_o,
  output logic mrd_o,
  output logic mop_o,
  output logic done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (is_mem_i && !is_bad_i) ? ST_MRD : ST_EXEC;
      ST_EXEC: state_d = ST_IDLE;
      ST_MRD:  state_d = ST_MOP;
      ST_MOP:  state_d = is_wr_i ? ST_FIN : ST_IDLE;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign ld_o   = idle_o && start_i;
  assign exec_o = (state_q == ST_EXEC);
  assign mrd_o  = (state_q == ST_MRD);
  assign mop_o  = (state_q == ST_MOP);
  assign done_o = exec_o || (mop_o && !is_wr_i) || (state_q == ST_FIN);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RD_THEN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_o |=> mop_o); // R7
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] hl_i,
  output logic [2:0]        rf_rsel_o,
  input  logic [7:0]        rf_rdata_i,
  output logic              rf_we_o,
  output logic [2:0]        rf_wsel_o,
  output logic [7:0]        rf_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [3:0]        flags_i,
  output logic [3:0]        flags_o,
  output logic              flag_we_o,
  output logic              done_o,
  output logic              err_o
);
  logic [DATA_W-1:0] op_q, op_cur, opnd, result;
  logic [ADDR_W-1:0] hl_q;
  op_dec_t           dec;
  logic              is_mem, is_wr, is_bad;
  logic              idle, ld, exec, mrd, mop, done;

  // decode the live byte while idle, the captured byte otherwise
  assign op_cur = idle ? opcode_i : op_q;

  bitop_decode u_dec (
    .opcode_i (op_cur),
    .dec_o    (dec),
    .is_mem_o (is_mem),
    .is_wr_o  (is_wr),
    .is_bad_o (is_bad)
  );

  bitop_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .is_mem_i (is_mem),
    .is_bad_i (is_bad),
    .is_wr_i  (is_wr),
    .idle_o   (idle),
    .ld_o     (ld),
    .exec_o   (exec),
    .mrd_o    (mrd),
    .mop_o    (mop),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0;
      hl_q <= '0;
    end else if (ld) begin
      op_q <= opcode_i;
      hl_q <= hl_i;
    end
  end

  assign opnd = mop ? mem_rdata_i : rf_rdata_i;

  bitop_alu u_alu (
    .cls_i    (dec.cls),
    .idx_i    (dec.idx),
    .opnd_i   (opnd),
    .flags_i  (flags_i),
    .result_o (result),
    .flags_o  (flags_o)
  );

  assign rf_rsel_o   = dec.sel;
  assign rf_wsel_o   = dec.sel;
  assign rf_wdata_o  = result;
  assign rf_we_o     = exec && is_wr;
  assign mem_addr_o  = hl_q;
  assign mem_re_o    = mrd;
  assign mem_we_o    = mop && is_wr;
  assign mem_wdata_o = result;
  assign flag_we_o   = (exec || mop) && (dec.cls == CLS_TEST);
  assign done_o      = done;
  assign err_o       = done && is_bad;

  AST_WB_REG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wsel_o != SEL_MEM)); // R1
  AST_TEST_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (!flags_o[FLG_N] && flags_o[FLG_H] && (flags_o[FLG_C] == flags_i[FLG_C]))); // R3
  AST_TEST_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (!rf_we_o && !mem_we_o)); // R3
  AST_WR_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || mem_we_o) |-> (!flag_we_o && (flags_o == flags_i))); // R6
  AST_MEM_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o)); // R7
  AST_MEM_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $stable(mem_addr_o)); // R7
  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> done_o); // R7
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, mem_re_o, mem_we_o})); // R7
  AST_ERR_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(rf_we_o || mem_re_o || mem_we_o || flag_we_o)); // R9
endmodule

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;
  localparam int unsigned ADDR_W = 16;
  localparam int NVEC = 13;
  // {opcode, operand value}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h47, 8'h01}, {8'h7E, 8'h7F}, {8'h50, 8'hFB}, {8'h59, 8'h08},
    {8'h82, 8'hFF}, {8'hBD, 8'h80}, {8'h86, 8'h01}, {8'hC3, 8'h00},
    {8'hFC, 8'h7F}, {8'hEE, 8'h00}, {8'hD7, 8'h04}, {8'h00, 8'h55},
    {8'h36, 8'hAA}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [ADDR_W-1:0] hl_i;
  logic [2:0] rf_rsel_o, rf_wsel_o;
  logic [7:0] rf_rdata_i, rf_wdata_o, mem_wdata_o;
  logic [7:0] mem_rdata_i = '0;
  logic rf_we_o, mem_re_o, mem_we_o, flag_we_o, done_o, err_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [3:0] flags_i, flags_o;

  logic [7:0] regs [8];
  logic [7:0] mem [256];
  logic [3:0] flags_q = '0;

  int checks = 0, errors = 0;
  int n_rfw = 0, n_mw = 0, n_mr = 0, n_fw = 0, n_done = 0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
  logic [2:0] last_wsel = '0;

  always #2 clk = ~clk;

  assign rf_rdata_i = regs[rf_rsel_o];
  assign hl_i = {regs[4], regs[5]};
  assign flags_i = flags_q;

  bitop_unit #(.ADDR_W(ADDR_W)) u_bitop_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i), .hl_i(hl_i),
    .rf_rsel_o(rf_rsel_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_wsel_o(rf_wsel_o),
    .rf_wdata_o(rf_wdata_o), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
    .mem_rdata_i(mem_rdata_i), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .flags_i(flags_i), .flags_o(flags_o), .flag_we_o(flag_we_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge: sample outputs, apply environment updates after the rising edge
  task automatic tick();
    logic p_rfw, p_mw, p_mr, p_fw;
    logic [2:0] p_sel;
    logic [7:0] p_rd, p_md;
    logic [ADDR_W-1:0] p_addr;
    logic [3:0] p_flg;
    p_rfw = rf_we_o; p_sel = rf_wsel_o; p_rd = rf_wdata_o;
    p_mw = mem_we_o; p_mr = mem_re_o; p_addr = mem_addr_o; p_md = mem_wdata_o;
    p_fw = flag_we_o; p_flg = flags_o;
    if (done_o) n_done++;
    @(posedge clk);
    #1;
    if (p_rfw) begin regs[p_sel] = p_rd; n_rfw++; last_wsel = p_sel; end
    if (p_mw) begin mem[p_addr[7:0]] = p_md; n_mw++; wr_addr = p_addr; end
    if (p_mr) begin mem_rdata_i = mem[p_addr[7:0]]; n_mr++; rd_addr = p_addr; end
    if (p_fw) begin flags_q = p_flg; n_fw++; end
    @(negedge clk);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] op2, input bit second,
                        output int lat, output logic err_seen);
    start_i = 1'b1; opcode_i = op;
    tick();
    start_i = second; opcode_i = op2;
    lat = 0; err_seen = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      if (done_o && lat == 0) begin lat = c; err_seen = err_o; end
      tick();
      start_i = 1'b0;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] exp_regs [8];
    logic [3:0] exp_flags;
    logic [ADDR_W-1:0] hl_exp;
    logic [7:0] op, val, exp_val;
    logic [1:0] cls;
    logic [2:0] bi, sel;
    int lat, b_rfw, b_mw, b_mr, b_fw, b_done, exp_lat, same;
    logic err_seen;
    string tag;

    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;

    // R10 reset state
    #3;
    chk("R10", "done_o in reset", int'(done_o), 0);
    chk("R10", "err_o in reset", int'(err_o), 0);
    chk("R10", "strobes in reset", int'({rf_we_o, mem_re_o, mem_we_o, flag_we_o}), 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      op = VEC[v][15:8]; val = VEC[v][7:0];
      cls = op[7:6]; bi = op[5:3]; sel = op[2:0];
      for (int i = 0; i < 8; i++) regs[i] = 8'(8'h11 * (i + 1));
      regs[4] = 8'h9C; regs[5] = 8'h3A;
      if (sel != 3'd6) regs[sel] = val; else mem[regs[5]] = val;
      flags_q = 4'(v * 5 + 3);
      hl_exp = {regs[4], regs[5]};
      for (int i = 0; i < 8; i++) exp_regs[i] = regs[i];
      exp_val = val;
      if (cls == 2'd2) exp_val = val & ~(8'h01 << bi);
      if (cls == 2'd3) exp_val = val | (8'h01 << bi);
      if (sel != 3'd6) exp_regs[sel] = exp_val;
      exp_flags = flags_q;
      if (cls == 2'd1) exp_flags = {~val[bi], 1'b0, 1'b1, flags_q[0]};
      exp_lat = (cls == 2'd0 || sel != 3'd6) ? 1 : (cls == 2'd1 ? 2 : 3);
      tag = (cls == 2'd0) ? "R9" : (cls == 2'd1) ? "R2" : (cls == 2'd2) ? "R4" : "R5";

      b_rfw = n_rfw; b_mw = n_mw; b_mr = n_mr; b_fw = n_fw; b_done = n_done;
      run_op(op, 8'h00, 1'b0, lat, err_seen);

      chk("R8", $sformatf("latency op=%02h", op), lat, exp_lat);
      chk("R8", $sformatf("done pulses op=%02h", op), n_done - b_done, 1);
      chk("R9", $sformatf("err op=%02h", op), int'(err_seen), int'(cls == 2'd0));
      chk(tag, $sformatf("reg writes op=%02h", op), n_rfw - b_rfw, int'(cls[1] && sel != 3'd6));
      chk("R7", $sformatf("mem writes op=%02h", op), n_mw - b_mw, int'(cls[1] && sel == 3'd6));
      chk("R7", $sformatf("mem reads op=%02h", op), n_mr - b_mr, int'(cls != 2'd0 && sel == 3'd6));
      chk(cls == 2'd1 ? "R3" : "R6", $sformatf("flag writes op=%02h", op), n_fw - b_fw,
          int'(cls == 2'd1));
      chk(cls == 2'd1 ? "R3" : "R6", $sformatf("flags op=%02h", op), int'(flags_q), int'(exp_flags));
      if (sel == 3'd6) begin
        chk(tag, $sformatf("mem byte op=%02h", op), int'(mem[hl_exp[7:0]]), int'(exp_val));
        if (cls != 2'd0) chk("R7", "read addr", int'(rd_addr), int'(hl_exp));
        if (cls[1]) chk("R7", "write addr", int'(wr_addr), int'(hl_exp));
      end else begin
        chk(tag, $sformatf("target reg op=%02h", op), int'(regs[sel]), int'(exp_val));
        if (cls[1]) chk("R1", $sformatf("write selector op=%02h", op), int'(last_wsel), int'(sel));
      end
      same = 1;
      for (int i = 0; i < 8; i++) if (regs[i] !== exp_regs[i]) same = 0;
      chk("R1", $sformatf("register view op=%02h", op), same, 1);
    end

    // R8 start while busy is ignored: SET 1,(HL) then RES 0,B one cycle later
    for (int i = 0; i < 8; i++) regs[i] = 8'hFF;
    regs[4] = 8'h12; regs[5] = 8'h44; mem[8'h44] = 8'h00;
    b_rfw = n_rfw; b_done = n_done; b_mw = n_mw;
    run_op(8'hCE, 8'h80, 1'b1, lat, err_seen);
    chk("R8", "busy start done pulses", n_done - b_done, 1);
    chk("R8", "busy start reg writes", n_rfw - b_rfw, 0);
    chk("R8", "busy start B kept", int'(regs[0]), 8'hFF);
    chk("R7", "busy start mem result", int'(mem[8'h44]), 8'h02);
    chk("R7", "busy start mem writes", n_mw - b_mw, 1);
    chk("R8", "busy start latency", lat, 3);

    // R2 test of bit 7 with carry clear then set, back to back
    regs[7] = 8'h80; flags_q = 4'b0000;
    run_op(8'h7F, 8'h00, 1'b0, lat, err_seen);
    chk("R2", "BIT 7,A one", int'(flags_q), 4'b0010);
    regs[7] = 8'h7F; flags_q = 4'b0001;
    run_op(8'h7F, 8'h00, 1'b0, lat, err_seen);
    chk("R3", "BIT 7,A zero carry kept", int'(flags_q), 4'b1011);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule